// File: doc/BRIEF.md
# Converter Sample Recoder and Serial Word Shifter

This block sits behind a 14-bit data converter core. It takes each two's-complement sample and rewrites it into one of three number codes: two's complement left as it is, offset binary, or Gray code. A final stage can complement every bit. The block then sends the word out one bit at a time, most significant bit first, advancing by one bit on each cycle in which a bit-rate enable is high. A frame marker shows when the first bit of each word is on the line, so the receiver can find word boundaries.

The code select and the invert control are plain inputs. Both are captured together with the sample when a word is loaded, so a change made while a word is in flight never splits that word. A new sample is taken only when the shifter is empty. A sample that arrives while a word is still being sent is dropped and sets a sticky overrun flag.

Top module: `adc_word_serializer`

## Requirements
- R1: With `fmt_sel` = 0 (and also the unused value 3) the loaded word equals the input sample unchanged.
- R2: With `fmt_sel` = 1 the loaded word is offset binary: the input with bit 13 complemented (for example 0x0000 becomes 0x2000 and 0x1FFF becomes 0x3FFF).
- R3: With `fmt_sel` = 2 the loaded word is the Gray code of the offset-binary word b: bit 13 equals b[13] and bit i equals b[i+1] XOR b[i] for i below 13 (for example 0x0000 becomes 0x3000).
- R4: When `inv_en` is 1, all 14 bits of the recoded word are complemented after the recoding.
- R5: A loaded word appears on `ser_out` bit 13 first. The line moves to the next bit after each cycle in which `bit_en` is high and holds while `bit_en` is low. After 14 enabled cycles the word has been fully sent.
- R6: `frame_out` is high exactly while bit 13 of a word is on `ser_out`, that is, from the cycle after the load until the first enabled cycle.
- R7: A sample with `smp_valid` high is accepted only when no bits remain to be sent. A sample that arrives while bits remain is dropped and sets `overrun`, which stays high until reset.
- R8: `fmt_sel` and `inv_en` are sampled only in the load cycle. Changing them while a word is being sent does not alter that word.
- R9: During and right after reset, `ser_out`, `frame_out` and `overrun` are 0 and the shifter is empty.
- R10: When no word is in progress, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit is consumed per high cycle |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Two's-complement sample |
| fmt_sel | input | 2 | Output code: 0 two's complement, 1 offset binary, 2 Gray, 3 as 0 |
| inv_en | input | 1 | Complement the recoded word |
| ser_out | output | 1 | Serial data bit |
| frame_out | output | 1 | High while the word's first bit is presented |
| overrun | output | 1 | Sticky flag for dropped samples |

## Verification
The hardest case to reach is a sample strobe that lands in the same cycle as the enable that consumes the last bit of a word. The shifter is still busy in that cycle, so the sample must be dropped and must set overrun. Long runs of random stimulus, with a sparse enable and a dense strobe, hit this edge many times. A behavioural queue model decides on every clock whether each strobe is accepted, and the bench compares the outputs against it. Directed words that change the code and invert controls partway through check that these settings are captured only at load.

// File: rtl/adc_word_serializer.sv
module adc_word_serializer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_data,
  input  logic [1:0]   fmt_sel,
  input  logic         inv_en,
  output logic         ser_out,
  output logic         frame_out,
  output logic         overrun
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg, offs, gray, recoded, coded;
  logic [CW-1:0] left;
  logic          busy, load;

  assign offs  = {~smp_data[W-1], smp_data[W-2:0]};
  assign gray  = offs ^ (offs >> 1);
  assign coded = inv_en ? ~recoded : recoded;

  always_comb begin
    case (fmt_sel)
      2'd1:    recoded = offs;
      2'd2:    recoded = gray;
      default: recoded = smp_data;
    endcase
  end

  assign busy = (left != '0);
  assign load = smp_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      left    <= '0;
      overrun <= 1'b0;
    end else begin
      if (load) begin
        shreg <= coded;
        left  <= CW'(W);
      end else if (bit_en && busy) begin
        shreg <= shreg << 1;
        left  <= left - 1'b1;
      end
      if (smp_valid && busy)
        overrun <= 1'b1;
    end
  end

  assign ser_out   = busy && shreg[W-1];
  assign frame_out = (left == CW'(W));
endmodule

// File: rtl/adc_word_serializer_checker.sv
module adc_word_serializer_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic smp_valid,
  input logic ser_out,
  input logic frame_out,
  input logic overrun,
  input logic busy
);
  a_r9_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!overrun && !frame_out && !ser_out));

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && busy) |=> overrun);

  a_r7_no_spurious_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (!overrun && !(smp_valid && busy)) |=> !overrun);

  a_r6_frame_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !busy) |=> frame_out);

  a_r6_frame_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_out && bit_en) |=> !frame_out);

  a_r5_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> ($stable(ser_out) && $stable(frame_out)));
endmodule

bind adc_word_serializer adc_word_serializer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .smp_valid(smp_valid),
  .ser_out(ser_out), .frame_out(frame_out), .overrun(overrun), .busy(busy)
);

// File: tb/adc_word_serializer_bench.sv
module adc_word_serializer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        smp_valid = 1'b0;
  logic [13:0] smp_data = '0;
  logic [1:0]  fmt_sel = '0;
  logic        inv_en = 1'b0;
  logic        ser_out, frame_out, overrun;

  int checks = 0;
  int fails  = 0;
  bit q[$];
  bit m_ovr = 1'b0;

  always #2.5 clk = ~clk;

  adc_word_serializer u_adc_word_serializer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .smp_valid(smp_valid),
    .smp_data(smp_data), .fmt_sel(fmt_sel), .inv_en(inv_en),
    .ser_out(ser_out), .frame_out(frame_out), .overrun(overrun)
  );

  function automatic int encode(int d, int f, bit inv);
    int b, g;
    b = (f == 1 || f == 2) ? ((d + 8192) % 16384) : d;
    if (f == 2) begin
      g = 0;
      for (int i = 13; i >= 0; i--) begin
        if (i == 13) g += ((b >> 13) & 1) << 13;
        else         g += (((b >> (i + 1)) ^ (b >> i)) & 1) << i;
      end
      b = g;
    end
    if (inv) b = 16383 - b;
    return b;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(bit v, int d, int f, bit inv, bit en);
    int w;
    smp_valid = v; smp_data = d[13:0]; fmt_sel = f[1:0]; inv_en = inv; bit_en = en;
    if (v && q.size() != 0) m_ovr = 1'b1;
    if (v && q.size() == 0) begin
      w = encode(d, f, inv);
      for (int i = 13; i >= 0; i--) q.push_back(bit'((w >> i) & 1));
    end else if (en && q.size() != 0) begin
      void'(q.pop_front());
    end
    @(posedge clk);
    @(negedge clk);
    check("R5/R10 ser_out", ser_out, (q.size() != 0) ? q[0] : 0);
    check("R6 frame_out", frame_out, q.size() == 14);
    check("R7 overrun", overrun, m_ovr);
  endtask

  task automatic send_word(string tag, int d, int f, bit inv, int mf, bit minv, int exp);
    int got = 0;
    tick(1'b1, d, f, inv, 1'b0);
    for (int i = 0; i < 14; i++) begin
      got = (got << 1) | ser_out;
      tick(1'b0, 0, mf, minv, 1'b1);
    end
    check(tag, got, exp);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset ser_out", ser_out, 0);
    check("R9 reset frame_out", frame_out, 0);
    check("R9 reset overrun", overrun, 0);
    rst_n = 1'b1;
    tick(1'b0, 0, 0, 0, 1'b1);

    send_word("R1 fullscale pos", 14'h1FFF, 0, 0, 0, 0, 14'h1FFF);
    send_word("R1 fullscale neg", 14'h2000, 0, 0, 0, 0, 14'h2000);
    send_word("R1 code3 passthrough", 14'h1234, 3, 0, 3, 0, 14'h1234);
    send_word("R2 offset zero", 14'h0000, 1, 0, 1, 0, 14'h2000);
    send_word("R2 offset pos", 14'h1FFF, 1, 0, 1, 0, 14'h3FFF);
    send_word("R2 offset minus1", 14'h3FFF, 1, 0, 1, 0, 14'h1FFF);
    send_word("R3 gray zero", 14'h0000, 2, 0, 2, 0, 14'h3000);
    send_word("R3 gray minus1", 14'h3FFF, 2, 0, 2, 0, 14'h1000);
    send_word("R4 invert offset", 14'h0000, 1, 1, 1, 1, 14'h1FFF);
    send_word("R4 invert gray", 14'h0000, 2, 1, 2, 1, 14'h0FFF);
    send_word("R8 change mid word", 14'h0000, 1, 0, 2, 1, 14'h2000);
    send_word("R8 change mid word inv", 14'h1FFF, 0, 1, 1, 0, 14'h2000);
    check("R7 no overrun yet", overrun, 0);

    for (int n = 0; n < 4000; n++) begin
      tick(($urandom % 5) == 0, $urandom % 16384, $urandom % 4,
           $urandom % 2, (n < 2000) ? (($urandom % 2) == 0) : (($urandom % 4) == 0));
    end
    check("R7 overrun reached", overrun, 1);

    rst_n = 1'b0;
    q.delete(); m_ovr = 1'b0;
    @(negedge clk);
    check("R9 overrun cleared", overrun, 0);
    check("R9 frame cleared", frame_out, 0);
    rst_n = 1'b1;
    tick(1'b0, 0, 0, 0, 1'b0);
    send_word("R5 after reset", 14'h2AAA, 0, 0, 0, 0, 14'h2AAA);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule